// File: doc/BRIEF.md
# Card Bus Mode and Relative Address Selector

This block sits behind the command decoder of a removable flash card controller. It keeps the card's bus mode (native multi-card bus or SPI), the 16-bit relative address the host assigns during identification, and the card's selected or standby state. For every decoded command it reports, one cycle after the command strobe, whether the command is meant for this card. The serial framer, CRC checker, response builder and memory core sit outside the block and consume its outputs.

The card starts in native mode after power-on reset. If the host holds chip select low while issuing the reset command (command 0), the card switches to SPI mode and stays there until the next power-on reset. In native mode, the address carried in the upper half of the argument decides which card a command targets. The reserved address 0x0000 sends every card to standby at once. In SPI mode there is no address matching and there are no broadcast commands; the chip-select level decides instead. A card that is programming keeps its selected state if chip select is released during programming.

Top module: `card_mode_addr_sel`

## Requirements
- R1: After power-on reset (`rst_n` low), `spi_mode` is 0, `card_rca` is 0x0001, `card_selected` is 0 and `cmd_accept` is 0.
- R2: Command 0 strobed while `cs_n` is 0 sets `spi_mode` on the next cycle. Command 0 strobed while `cs_n` is 1 leaves the card in native mode and returns it to standby. In native mode, command 0 is accepted.
- R3: Once `spi_mode` is 1, it stays 1 until power-on reset, whatever commands follow.
- R4: In native mode, command 3 loads `card_rca` from `cmd_arg[31:16]` and is accepted only if the card is in standby and that field is not 0x0000. Otherwise it is rejected and `card_rca` is unchanged.
- R5: In native mode, command 7 selects the card when `cmd_arg[31:16]` equals `card_rca` and is accepted. Any other address moves the card to standby and the command is not accepted.
- R6: In native mode, command 7 with `cmd_arg[31:16]` = 0x0000 always leaves the card in standby and is never accepted.
- R7: In native mode, commands 9, 10, 13 and 15 are accepted exactly when `cmd_arg[31:16]` equals `card_rca`, in either select state.
- R8: In native mode, commands 1 and 2 are always accepted. Every command number not named in R2 to R7 is accepted only while the card is selected.
- R9: In SPI mode, commands 2, 3 and 7 are never accepted, and `card_rca` never changes.
- R10: In SPI mode, every other command is accepted exactly when `cs_n` is 0 at the strobe.
- R11: In SPI mode, `card_selected` follows the inverse of `cs_n` one cycle later. The exception is when `prog_active` is 1: a selected card then stays selected.
- R12: `cmd_accept` is high only in the cycle after a `cmd_valid` strobe, and only for an accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_idx | input | 6 | Command number |
| cmd_arg | input | 32 | Command argument; bits 31:16 carry an address |
| cs_n | input | 1 | Chip-select level, active low |
| prog_active | input | 1 | Flash programming in progress |
| spi_mode | output | 1 | 1 = SPI mode, 0 = native mode |
| card_rca | output | 16 | Stored relative address |
| card_selected | output | 1 | 1 = selected, 0 = standby |
| cmd_accept | output | 1 | Command of the previous cycle is for this card |

## Verification
The bound checker watches, on every cycle, the properties that hold without history. These are: SPI mode never drops; the address stays fixed and nonzero once in SPI mode; addressing commands and released chip select are rejected in SPI mode; address zero deselects; the programming hold works; and accept appears only after a strobe. Only the bench scenarios show the outcomes that depend on stored history. These include loading a new address and then matching or missing it, rejecting command 3 while selected, the gating of transfer commands on select state, and the full path from native mode to SPI mode with chip select toggled around programming.

// File: rtl/card_sel_pkg.sv
package card_sel_pkg;

    typedef enum logic [2:0] {
        CLS_RESET,
        CLS_OPCOND,
        CLS_IDENT,
        CLS_SETADDR,
        CLS_SELECT,
        CLS_ADDRD,
        CLS_XFER
    } cmd_cls_e;

    localparam int unsigned IDX_W     = 6;
    localparam int unsigned NUM_ADDRD = 4;

    localparam logic [IDX_W-1:0] IDX_GO_IDLE  = 6'd0;
    localparam logic [IDX_W-1:0] IDX_OP_COND  = 6'd1;
    localparam logic [IDX_W-1:0] IDX_ALL_ID   = 6'd2;
    localparam logic [IDX_W-1:0] IDX_SET_ADDR = 6'd3;
    localparam logic [IDX_W-1:0] IDX_SEL_DSEL = 6'd7;

    // Commands that name a card by address without needing it selected.
    localparam logic [NUM_ADDRD*IDX_W-1:0] ADDRD_LIST =
        {6'd15, 6'd13, 6'd10, 6'd9};

endpackage

// File: rtl/cmd_classify.sv
module cmd_classify
    import card_sel_pkg::*;
#(
    parameter int unsigned N_ADDRD = NUM_ADDRD,
    parameter logic [N_ADDRD*IDX_W-1:0] ADDRD_IDX = ADDRD_LIST
) (
    input  logic [IDX_W-1:0] cmd_idx,
    output cmd_cls_e         cls
);
    logic [N_ADDRD-1:0] addrd_hit;

    for (genvar g = 0; g < N_ADDRD; g++) begin : g_addrd
        assign addrd_hit[g] = (cmd_idx == ADDRD_IDX[g*IDX_W +: IDX_W]);
    end

    always_comb begin
        if (cmd_idx == IDX_GO_IDLE)       cls = CLS_RESET;
        else if (cmd_idx == IDX_OP_COND)  cls = CLS_OPCOND;
        else if (cmd_idx == IDX_ALL_ID)   cls = CLS_IDENT;
        else if (cmd_idx == IDX_SET_ADDR) cls = CLS_SETADDR;
        else if (cmd_idx == IDX_SEL_DSEL) cls = CLS_SELECT;
        else if (|addrd_hit)              cls = CLS_ADDRD;
        else                              cls = CLS_XFER;
    end
endmodule

// File: rtl/mode_latch.sv
module mode_latch
    import card_sel_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_valid,
    input  cmd_cls_e cls,
    input  logic     cs_n,
    output logic     spi_mode
);
    typedef struct packed {
        logic spi;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_valid && cls == CLS_RESET && !cs_n) begin
            st_d.spi = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign spi_mode = st_q.spi;
endmodule

// File: rtl/rca_reg.sv
module rca_reg
    import card_sel_pkg::*;
#(
    parameter int unsigned     ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RST_ADDR = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  cmd_cls_e          cls,
    input  logic [ADDR_W-1:0] arg_addr,
    input  logic              spi_mode,
    input  logic              selected,
    output logic [ADDR_W-1:0] rca
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } rca_st_t;

    rca_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_valid && !spi_mode && cls == CLS_SETADDR &&
            !selected && arg_addr != '0) begin
            st_d.addr = arg_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{addr: RST_ADDR};
        else        st_q <= st_d;
    end

    assign rca = st_q.addr;
endmodule

// File: rtl/sel_ctrl.sv
module sel_ctrl
    import card_sel_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  cmd_cls_e          cls,
    input  logic [ADDR_W-1:0] arg_addr,
    input  logic [ADDR_W-1:0] rca,
    input  logic              spi_mode,
    input  logic              cs_n,
    input  logic              prog_active,
    output logic              selected,
    output logic              accept
);
    typedef struct packed {
        logic sel;
        logic acc;
    } sel_st_t;

    sel_st_t st_d, st_q;
    logic    addr_match;

    assign addr_match = (arg_addr == rca);

    always_comb begin
        st_d     = st_q;
        st_d.acc = 1'b0;
        if (spi_mode) begin
            st_d.sel = !cs_n || (st_q.sel && prog_active);
            if (cmd_valid && !cs_n) begin
                case (cls)
                    CLS_IDENT, CLS_SETADDR, CLS_SELECT: st_d.acc = 1'b0;
                    default:                            st_d.acc = 1'b1;
                endcase
            end
        end else if (cmd_valid) begin
            case (cls)
                CLS_RESET: begin
                    st_d.acc = 1'b1;
                    st_d.sel = 1'b0;
                end
                CLS_OPCOND, CLS_IDENT: st_d.acc = 1'b1;
                CLS_SETADDR: st_d.acc = !st_q.sel && arg_addr != '0;
                CLS_SELECT: begin
                    st_d.acc = addr_match;
                    st_d.sel = addr_match;
                end
                CLS_ADDRD: st_d.acc = addr_match;
                default:   st_d.acc = st_q.sel;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign selected = st_q.sel;
    assign accept   = st_q.acc;
endmodule

// File: rtl/card_mode_addr_sel.sv
module card_mode_addr_sel
    import card_sel_pkg::*;
#(
    parameter int unsigned       ARG_W    = 32,
    parameter int unsigned       ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RST_ADDR = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [ARG_W-1:0]  cmd_arg,
    input  logic              cs_n,
    input  logic              prog_active,
    output logic              spi_mode,
    output logic [ADDR_W-1:0] card_rca,
    output logic              card_selected,
    output logic              cmd_accept
);
    localparam int unsigned LOW_W = ARG_W - ADDR_W;

    cmd_cls_e          cls;
    logic [ADDR_W-1:0] arg_addr;
    logic              unused_arg_low;

    assign arg_addr       = cmd_arg[ARG_W-1 -: ADDR_W];
    assign unused_arg_low = ^cmd_arg[LOW_W-1:0];

    cmd_classify u_cls (
        .cmd_idx (cmd_idx),
        .cls     (cls)
    );

    mode_latch u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cls       (cls),
        .cs_n      (cs_n),
        .spi_mode  (spi_mode)
    );

    rca_reg #(.ADDR_W(ADDR_W), .RST_ADDR(RST_ADDR)) u_rca (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cls       (cls),
        .arg_addr  (arg_addr),
        .spi_mode  (spi_mode),
        .selected  (card_selected),
        .rca       (card_rca)
    );

    sel_ctrl #(.ADDR_W(ADDR_W)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cls         (cls),
        .arg_addr    (arg_addr),
        .rca         (card_rca),
        .spi_mode    (spi_mode),
        .cs_n        (cs_n),
        .prog_active (prog_active),
        .selected    (card_selected),
        .accept      (cmd_accept)
    );
endmodule

// File: rtl/card_mode_addr_sel_chk.sv
module card_mode_addr_sel_chk #(
    parameter int unsigned ARG_W  = 32,
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [5:0]        cmd_idx,
    input logic [ARG_W-1:0]  cmd_arg,
    input logic              cs_n,
    input logic              prog_active,
    input logic              spi_mode,
    input logic [ADDR_W-1:0] card_rca,
    input logic              card_selected,
    input logic              cmd_accept
);
    logic [ADDR_W-1:0] a_addr;
    logic              a_ident;
    assign a_addr  = cmd_arg[ARG_W-1 -: ADDR_W];
    assign a_ident = (cmd_idx == 6'd2) || (cmd_idx == 6'd3) || (cmd_idx == 6'd7);

    p_spi_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_mode && cmd_valid && cmd_idx == 6'd0 && !cs_n) |=> spi_mode);

    p_spi_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        spi_mode |=> spi_mode);

    p_rca_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        card_rca != '0);

    p_zero_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_mode && cmd_valid && cmd_idx == 6'd7 && a_addr == '0)
        |=> (!card_selected && !cmd_accept));

    p_spi_rca_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        spi_mode |=> $stable(card_rca));

    p_spi_ident_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_mode && cmd_valid && a_ident) |=> !cmd_accept);

    p_spi_cs_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_mode && cmd_valid && cs_n) |=> !cmd_accept);

    p_prog_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_mode && card_selected && prog_active) |=> card_selected);

    p_accept_after_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !cmd_accept);
endmodule

bind card_mode_addr_sel card_mode_addr_sel_chk u_chk (.*);

// File: tb/card_mode_addr_sel_test.sv
`timescale 1ns/1ps
module card_mode_addr_sel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [5:0]  cmd_idx = '0;
    logic [31:0] cmd_arg = '0;
    logic        cs_n = 1'b1;
    logic        prog_active = 1'b0;
    logic        spi_mode;
    logic [15:0] card_rca;
    logic        card_selected;
    logic        cmd_accept;

    int errors = 0;
    int checks = 0;
    bit seen   = 1'b0;
    bit exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    card_mode_addr_sel uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: one strobe, expected accept pushed into the scoreboard
    task automatic issue(input logic [5:0] idx, input logic [31:0] arg,
                         input logic cs, input bit exp_acc, input string req);
        @(negedge clk);
        cmd_idx   = idx;
        cmd_arg   = arg;
        cs_n      = cs;
        cmd_valid = 1'b1;
        exp_q.push_back(exp_acc);
        tag_q.push_back(req);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic set_cs(input logic v);
        @(negedge clk);
        cs_n = v;
        @(negedge clk);
    endtask

    always @(posedge clk) seen <= rst_n && cmd_valid;

    // monitor
    always @(negedge clk) begin
        if (seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12 actual=strobe expected=queued item");
            end else begin
                bit e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({t, " accept"}, {31'b0, cmd_accept}, {31'b0, e});
            end
        end else if (rst_n) begin
            chk("R12 idle accept", {31'b0, cmd_accept}, 32'd0);
        end
    end

    initial begin
        #4000000;
        errors++; checks++;
        $display("FAIL watchdog R12 actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 mode", {31'b0, spi_mode}, 32'd0);
        chk("R1 rca", {16'b0, card_rca}, 32'h0001);
        chk("R1 sel", {31'b0, card_selected}, 32'd0);
        chk("R1 acc", {31'b0, cmd_accept}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // native mode
        issue(6'd9,  32'h0001_0000, 1'b1, 1'b1, "R7 match");
        issue(6'd17, 32'h0,         1'b1, 1'b0, "R8 xfer standby");
        issue(6'd2,  32'h0,         1'b1, 1'b1, "R8 ident");
        issue(6'd1,  32'h0,         1'b1, 1'b1, "R8 opcond");
        issue(6'd3,  32'h0000_1234, 1'b1, 1'b0, "R4 zero addr");
        chk("R4 rca kept", {16'b0, card_rca}, 32'h0001);
        issue(6'd3,  32'hABCD_0000, 1'b1, 1'b1, "R4 load");
        chk("R4 rca loaded", {16'b0, card_rca}, 32'hABCD);
        issue(6'd9,  32'h0001_0000, 1'b1, 1'b0, "R7 old addr");
        issue(6'd13, 32'hABCD_0000, 1'b1, 1'b1, "R7 new addr");
        issue(6'd7,  32'h1234_0000, 1'b1, 1'b0, "R5 miss");
        chk("R5 sel miss", {31'b0, card_selected}, 32'd0);
        issue(6'd7,  32'hABCD_0000, 1'b1, 1'b1, "R5 hit");
        chk("R5 sel hit", {31'b0, card_selected}, 32'd1);
        issue(6'd3,  32'h5555_0000, 1'b1, 1'b0, "R4 while selected");
        chk("R4 rca unchanged", {16'b0, card_rca}, 32'hABCD);
        issue(6'd17, 32'h0,         1'b1, 1'b1, "R8 xfer selected");
        issue(6'd10, 32'h0001_0000, 1'b1, 1'b0, "R7 miss selected");
        issue(6'd7,  32'h0000_0000, 1'b1, 1'b0, "R6 zero");
        chk("R6 sel", {31'b0, card_selected}, 32'd0);
        issue(6'd17, 32'h0,         1'b1, 1'b0, "R8 xfer after deselect");
        issue(6'd7,  32'hABCD_0000, 1'b1, 1'b1, "R5 reselect");
        issue(6'd7,  32'h1111_0000, 1'b1, 1'b0, "R5 other addr");
        chk("R5 sel other", {31'b0, card_selected}, 32'd0);
        issue(6'd7,  32'hABCD_0000, 1'b1, 1'b1, "R5 reselect2");
        issue(6'd0,  32'h0,         1'b1, 1'b1, "R2 reset cs high");
        chk("R2 mode native", {31'b0, spi_mode}, 32'd0);
        chk("R2 sel idle", {31'b0, card_selected}, 32'd0);
        issue(6'd0,  32'h0,         1'b0, 1'b1, "R2 reset cs low");
        chk("R2 mode spi", {31'b0, spi_mode}, 32'd1);

        // SPI mode
        set_cs(1'b1);
        @(negedge clk);
        chk("R11 sel cs high", {31'b0, card_selected}, 32'd0);
        set_cs(1'b0);
        chk("R11 sel cs low", {31'b0, card_selected}, 32'd1);
        issue(6'd17, 32'h0,         1'b0, 1'b1, "R10 cs low");
        issue(6'd17, 32'h0,         1'b1, 1'b0, "R10 cs high");
        issue(6'd3,  32'h7777_0000, 1'b0, 1'b0, "R9 setaddr");
        chk("R9 rca", {16'b0, card_rca}, 32'hABCD);
        issue(6'd2,  32'h0,         1'b0, 1'b0, "R9 ident");
        issue(6'd7,  32'hABCD_0000, 1'b0, 1'b0, "R9 select");
        issue(6'd9,  32'h0,         1'b0, 1'b1, "R10 no addr match");
        issue(6'd0,  32'h0,         1'b1, 1'b0, "R10 reset cs high");
        chk("R3 stays spi", {31'b0, spi_mode}, 32'd1);

        set_cs(1'b0);
        @(negedge clk);
        prog_active = 1'b1;
        cs_n        = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R11 hold while programming", {31'b0, card_selected}, 32'd1);
        prog_active = 1'b0;
        @(negedge clk);
        chk("R11 release after programming", {31'b0, card_selected}, 32'd0);
        chk("R3 final mode", {31'b0, spi_mode}, 32'd1);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule